// File: doc/BRIEF.md
# Serial ADC Data Output Emulator

This block stands in for the digital output side of a serial sampling converter so that a host receiver can be exercised without analog parts. It watches a conversion strobe and a serial clock supplied by the host. On the rising edge of the strobe it captures a 14-bit parallel sample. It then counts rising serial clock edges and shifts the captured value out, most significant bit first, on a single data pin. An output-enable signal marks when the pin would be driven; at all other times the pin is modelled as high impedance.

Both the strobe and the serial clock are oversampled by a faster system clock. Each passes through a short synchroniser and a rising-edge detector, so the outputs follow the host's edges after a small fixed latency of system clocks. The host serial clock must stay well below the system clock rate. Reset is asynchronous and active low, with a synchronous release inside the block.

Top module: `adc_sdo_emu`

## Requirements
- R1: While reset is asserted and directly after it is released, `sdo_oe_o` is 0 and `sdo_o` is 0.
- R2: Serial clock edges that arrive before the first conversion strobe after reset leave `sdo_oe_o` at 0.
- R3: The rising edge of `conv_i` captures `sample_i`; changes to `sample_i` after that edge do not alter the frame being sent.
- R4: After a strobe rising edge, the first two rising serial clock edges leave `sdo_oe_o` at 0; the third raises it and puts bit 13 of the captured sample on `sdo_o`.
- R5: Rising serial clock edges 3 through 16 after the strobe present sample bits 13 down to 0, one bit per edge, each valid before the following rising edge.
- R6: `sdo_o` and `sdo_oe_o` change only in response to a detected rising edge of the serial clock or of the strobe.
- R7: The 17th and every later rising serial clock edge leave `sdo_oe_o` at 0 until the next strobe rising edge.
- R8: A strobe rising edge during a frame drops `sdo_oe_o` at once, captures a new sample and restarts the edge count; if it coincides with a detected serial clock edge, the strobe wins and that clock edge is not counted.
- R9: `sdo_o` is 0 whenever `sdo_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the host signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Conversion strobe from the host; rising edge starts a frame |
| sclk_i | input | 1 | Serial clock from the host |
| sample_i | input | 14 | Parallel sample value captured at the strobe |
| sdo_o | output | 1 | Serial data bit (0 when not driven) |
| sdo_oe_o | output | 1 | 1 while the data pin is driven, 0 for high impedance |

## Verification
On every cycle the assertions track their own count of serial clock edges since the last strobe and require the enable to be high exactly inside the 14-edge data window, the data to stay low when the enable is low, the outputs to move only after a detected edge, and the enable to drop after a strobe. Whether the bits carry the captured sample in the right order, that a later change of the parallel input is ignored, and that an aborted frame restarts with the new value are shown only by the bench's frames, which compare every bit with a value computed from the sample it drove.

// File: rtl/adc_sdo_emu_pkg.sv
package adc_sdo_emu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_SEND = 2'd2
  } frame_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int width_for(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/adc_sdo_emu_edge.sv
module adc_sdo_emu_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] pipe_q;
  logic [SYNC_STAGES-1:0] pipe_d;
  logic                   last_q;

  always_comb begin
    pipe_d[0] = sig_i;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      pipe_d[i] = pipe_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      last_q <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      last_q <= pipe_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = pipe_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/adc_sdo_emu_frame.sv
module adc_sdo_emu_frame
  import adc_sdo_emu_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int LEAD_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_rise_i,
  input  logic sclk_rise_i,
  output logic load_o,
  output logic step_o,
  output logic drive_o
);

  localparam int CNT_MAX = max_of(LEAD_EDGES, DATA_W - 1);
  localparam int CW      = width_for(CNT_MAX);
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_EDGES);
  localparam logic [CW-1:0] BIT_LAST  = CW'(DATA_W - 1);

  frame_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    if (conv_rise_i) begin
      state_d = ST_LEAD;
      cnt_d   = '0;
      cnt_en  = 1'b1;
      load_o  = 1'b1;
    end else if (sclk_rise_i) begin
      case (state_q)
        ST_LEAD: begin
          cnt_en = 1'b1;
          if (cnt_q == LEAD_LAST) begin
            state_d = ST_SEND;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SEND: begin
          if (cnt_q == BIT_LAST) begin
            state_d = ST_IDLE;
          end else begin
            cnt_en = 1'b1;
            cnt_d  = cnt_q + 1'b1;
            step_o = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign drive_o = (state_q == ST_SEND);

endmodule

// File: rtl/adc_sdo_emu_shift.sv
module adc_sdo_emu_shift #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] value_i,
  output logic              bit_o
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sh_en;

  always_comb begin
    sh_en = load_i | step_i;
    if (load_i) begin
      sh_d = value_i;
    end else begin
      sh_d = {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign bit_o = sh_q[DATA_W-1];

endmodule

// File: rtl/adc_sdo_emu.sv
module adc_sdo_emu #(
  parameter int DATA_W      = 14,
  parameter int LEAD_EDGES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       conv_rise;
  logic       sclk_rise;
  logic       load;
  logic       step;
  logic       drive;
  logic       bit_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];

  adc_sdo_emu_edge #(.SYNC_STAGES(SYNC_STAGES)) u_conv_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sig_i  (conv_i),
    .rise_o (conv_rise)
  );

  adc_sdo_emu_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sclk_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sig_i  (sclk_i),
    .rise_o (sclk_rise)
  );

  adc_sdo_emu_frame #(.DATA_W(DATA_W), .LEAD_EDGES(LEAD_EDGES)) u_frame (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .conv_rise_i (conv_rise),
    .sclk_rise_i (sclk_rise),
    .load_o      (load),
    .step_o      (step),
    .drive_o     (drive)
  );

  adc_sdo_emu_shift #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (load),
    .step_i  (step),
    .value_i (sample_i),
    .bit_o   (bit_now)
  );

  assign sdo_oe_o = drive;
  assign sdo_o    = drive & bit_now;

endmodule

// File: rtl/adc_sdo_emu_chk.sv
module adc_sdo_emu_chk #(
  parameter int DATA_W     = 14,
  parameter int LEAD_EDGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic conv_rise,
  input logic sclk_rise,
  input logic sdo_o,
  input logic sdo_oe_o
);

  localparam int EMAX = LEAD_EDGES + DATA_W + 1;
  localparam int EW   = $clog2(EMAX + 1);
  localparam logic [EW-1:0] WIN_LO = EW'(LEAD_EDGES + 1);
  localparam logic [EW-1:0] WIN_HI = EW'(LEAD_EDGES + DATA_W);
  localparam logic [EW-1:0] SAT    = EW'(EMAX);

  logic          seen_q;
  logic [EW-1:0] edges_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      edges_q <= '0;
    end else if (conv_rise) begin
      seen_q  <= 1'b1;
      edges_q <= '0;
    end else if (sclk_rise && edges_q != SAT) begin
      edges_q <= edges_q + 1'b1;
    end
  end

  // R1
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!sdo_oe_o && !sdo_o);
    end
  end

  assert_no_drive_before_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !sdo_oe_o);

  // R4 R5 R7: enable exactly inside the data window
  assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_o |-> (seen_q && edges_q >= WIN_LO && edges_q <= WIN_HI));

  assert_window_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && edges_q >= WIN_LO && edges_q <= WIN_HI) |-> sdo_oe_o);

  assert_quiet_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q > WIN_HI) |-> !sdo_oe_o);

  assert_edge_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sdo_o) || !$stable(sdo_oe_o)) |-> $past(sclk_rise || conv_rise));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rise |=> !sdo_oe_o);

  assert_low_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe_o |-> !sdo_o);

endmodule

bind adc_sdo_emu adc_sdo_emu_chk #(.DATA_W(DATA_W), .LEAD_EDGES(LEAD_EDGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_rise (conv_rise),
  .sclk_rise (sclk_rise),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o)
);

// File: tb/adc_sdo_emu_tb.sv
module adc_sdo_emu_tb;

  localparam int W    = 14;
  localparam int LEAD = 2;

  logic         clk;
  logic         rst_n;
  logic         conv_i;
  logic         sclk_i;
  logic [W-1:0] sample_i;
  logic         sdo_o;
  logic         sdo_oe_o;

  int checks;
  int errors;
  int cycles;
  bit done;

  adc_sdo_emu u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_i   (conv_i),
    .sclk_i   (sclk_i),
    .sample_i (sample_i),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit exp_oe(input int e);
    return (e >= LEAD + 1) && (e <= LEAD + W);
  endfunction

  function automatic bit exp_sdo(input logic [W-1:0] s, input int e);
    if (!exp_oe(e)) return 1'b0;
    return s[W - 1 - (e - LEAD - 1)];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial clock period; e is the edge index since the last strobe (0 = none)
  task automatic sclk_pulse(input int half, input int e, input logic [W-1:0] s, input bit armed);
    logic mid_oe, mid_sdo;
    sclk_i = 1'b1;
    wait_clk(half);
    mid_oe  = sdo_oe_o;
    mid_sdo = sdo_o;
    sclk_i  = 1'b0;
    wait_clk(half);
    if (!armed) begin
      check("R2 oe before first strobe", {15'd0, mid_oe}, 16'd0);
    end else begin
      if (e <= LEAD + 1)
        check($sformatf("R4 oe at edge %0d", e), {15'd0, mid_oe}, {15'd0, exp_oe(e)});
      else if (e <= LEAD + W)
        check($sformatf("R5 oe at edge %0d", e), {15'd0, mid_oe}, {15'd0, exp_oe(e)});
      else
        check($sformatf("R7 oe at edge %0d", e), {15'd0, mid_oe}, 16'd0);
      if (exp_oe(e))
        check($sformatf("R5 R3 bit at edge %0d", e), {15'd0, mid_sdo}, {15'd0, exp_sdo(s, e)});
      else
        check($sformatf("R9 sdo low at edge %0d", e), {15'd0, mid_sdo}, 16'd0);
    end
    check("R6 outputs hold until next edge", {14'd0, sdo_oe_o, sdo_o}, {14'd0, mid_oe, mid_sdo});
  endtask

  task automatic strobe(input logic [W-1:0] s, input bit in_frame);
    sample_i = s;
    conv_i   = 1'b1;
    wait_clk(3);
    conv_i   = 1'b0;
    sample_i = W'($urandom);
    wait_clk(6);
    if (in_frame) check("R8 oe low after abort", {15'd0, sdo_oe_o}, 16'd0);
    else          check("R4 oe low right after strobe", {15'd0, sdo_oe_o}, 16'd0);
    check("R9 sdo low after strobe", {15'd0, sdo_o}, 16'd0);
  endtask

  task automatic frame(input logic [W-1:0] s, input int n, input int half, input bit in_frame);
    strobe(s, in_frame);
    for (int e = 1; e <= n; e++) sclk_pulse(half, e, s, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    checks   = 0;
    errors   = 0;
    cycles   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    conv_i   = 1'b0;
    sclk_i   = 1'b0;
    sample_i = '0;
    wait_clk(2);
    check("R1 oe in reset", {15'd0, sdo_oe_o}, 16'd0);
    check("R1 sdo in reset", {15'd0, sdo_o}, 16'd0);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 oe after reset", {15'd0, sdo_oe_o}, 16'd0);
    check("R1 sdo after reset", {15'd0, sdo_o}, 16'd0);

    // R2: clocks with no strobe
    for (int i = 0; i < 5; i++) sclk_pulse(5, 0, '0, 1'b0);

    // directed patterns, R7 trailing edges included
    frame(14'h3FFF, 20, 5, 1'b0);
    frame(14'h0000, 17, 6, 1'b0);
    frame(14'h2AAA, 18, 5, 1'b0);
    frame(14'h1555, 16, 7, 1'b0);
    frame(14'h2001, 22, 5, 1'b0);

    // R8: abort mid-frame, then a full frame with the new value
    frame(14'h3C0F, 8, 5, 1'b0);
    frame(14'h0FF0, 18, 5, 1'b1);
    frame(14'h1234, 2, 6, 1'b0);
    frame(14'h2DB6, 17, 6, 1'b1);

    // random frames, some aborted
    for (int k = 0; k < 12; k++) begin
      logic [W-1:0] s;
      int half;
      int n;
      s    = W'($urandom);
      half = 5 + int'($urandom % 4);
      n    = ($urandom % 3 == 0) ? 1 + int'($urandom % 15) : 16 + int'($urandom % 5);
      frame(s, n, half, 1'b0);
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule